// File: doc/BRIEF.md
# Descriptor-Driven Packet Event Sequencer

This block walks a small table of 32-bit descriptors and turns each one into an ordered run of events for a downstream serial packetizer. Software loads the table through a one-word write port and then raises a start pulse. The block visits every table slot in ascending order and skips slots whose valid bit is clear. For each valid slot it can emit a line-start sync event, a long-packet header event, a run of payload sample events and a line-end sync event, in that order. Each part is switched on or off by the slot's own bits.

Payload samples come in 16 bits wide over a ready/valid input. They leave narrowed to the width the descriptor selects. The header carries the virtual channel and the byte count of the whole packed long packet. That packet is the header's own slot plus any later continuation slots, so one header can cover payload gathered from several slots of different widths. A slot may also hold the sequencer until a packet-sent acknowledge arrives. After the last slot the block gives a one-cycle done pulse.

The event port has no backpressure. Each event is valid for exactly one cycle, with a type code and a 32-bit data word. Sync events carry the virtual channel in data bits 31:30 and zeros elsewhere. Header events carry the virtual channel in bits 31:30 and the byte count in bits 29:0. Sample events carry the narrowed sample right-justified, with zeros above it.

Top module: `pktseq_top`

## Requirements
- R1: Reset clears every table slot to zero, so every slot is invalid, and holds evtValid, sampleReady and doneOut low. A start given on a table left at reset produces no events and one done pulse.
- R2: Slots are visited in ascending index order, from 0 to DEPTH-1. A slot whose bit 0 is clear produces no events and consumes no samples.
- R3: When bit 2 of a valid slot is set, a line-start event (type 1) comes before that slot's header and samples. When bit 1 is set, a line-end event (type 4) follows its samples. Both carry the slot's virtual channel in data bits 31:30.
- R4: When bit 27 of a valid slot is set, a header event (type 2) comes after any line-start event and before the samples. Its data holds the virtual channel from slot bits 4:3 in bits 31:30 and the byte count in bits 29:0. When bit 27 is clear, no header is emitted for that slot.
- R5: The header byte count is the sum of size times sample width, in bits, over the header slot and every later valid slot with bit 27 clear, up to the next valid slot with bit 27 set. The sum is divided by 8 and rounded up. Invalid slots in between add nothing.
- R6: A valid slot emits exactly as many sample events (type 3) as the size in bits 22:9, which counts samples. A size of 0 emits none. sampleReady is high only while a slot still has samples outstanding.
- R7: Slot bits 6:5 select the sample width: 00 gives 16 bits unchanged, 01 gives 14 bits (input bits 15:2), 10 gives 12 bits (input bits 15:4), and 11 is treated as 16 bits.
- R8: When bit 26 of a valid slot is set, the sequencer holds after that slot's last event until pktSentAck is high. No event and no done pulse appear while it holds.
- R9: doneOut pulses high for one cycle after the last slot has been handled, and never in the same cycle as an event.
- R10: A sample event appears in the cycle right after each cycle in which sampleValid and sampleReady are both high, and at no other time.
- R11: A start pulse that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Table write strobe |
| cfgWrAddr | input | IDX_W | Slot index to write |
| cfgWrData | input | 32 | Descriptor word to write |
| startPulse | input | 1 | Begins a walk of the table from slot 0 |
| pktSentAck | input | 1 | Packet-sent acknowledge that releases a hold requested by a slot |
| sampleValid | input | 1 | Input sample available |
| sampleData | input | 16 | Input sample |
| sampleReady | output | 1 | Block accepts a sample in this cycle |
| evtValid | output | 1 | Event present |
| evtType | output | 3 | Event code: 1 line-start, 2 header, 3 sample, 4 line-end, 0 when idle |
| evtData | output | 32 | Event data word |
| doneOut | output | 1 | One-cycle pulse when the walk ends |

## Verification
Most faults inside the control state show up at the event port within a handful of cycles. A wrong slot index or state ordering puts events in the wrong order, or from a slot that is not valid. A broken sample counter gives a payload one sample too short or too long, and sampleReady stays high past the end of the slot or drops before the size is met. An error in the chain walk changes only the header byte count. That value is visible as soon as the header event leaves, before any payload. The other place to look is a hold that is released early, which shows up as events or a done pulse appearing before the acknowledge.

// File: rtl/pktseq_pkg.sv
package pktseq_pkg;

  localparam int ENTRY_W = 32;
  localparam int SIZE_W  = 14;
  localparam int VC_W    = 2;
  localparam int BITS_W  = 5;

  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_LSTART = 3'd1,
    EV_HDR    = 3'd2,
    EV_SAMPLE = 3'd3,
    EV_LEND   = 3'd4
  } evt_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      emit;
    evt_kind_e kind;
    logic      take;
    logic      done;
  } seq_strobe_t;

  function automatic logic entValid(input logic [ENTRY_W-1:0] e);
    return e[0];
  endfunction

  function automatic logic entLineEnd(input logic [ENTRY_W-1:0] e);
    return e[1];
  endfunction

  function automatic logic entLineStart(input logic [ENTRY_W-1:0] e);
    return e[2];
  endfunction

  function automatic logic [VC_W-1:0] entVc(input logic [ENTRY_W-1:0] e);
    return e[4:3];
  endfunction

  function automatic logic [1:0] entWidth(input logic [ENTRY_W-1:0] e);
    return e[6:5];
  endfunction

  function automatic logic [SIZE_W-1:0] entSize(input logic [ENTRY_W-1:0] e);
    return e[22:9];
  endfunction

  function automatic logic entWaitAck(input logic [ENTRY_W-1:0] e);
    return e[26];
  endfunction

  function automatic logic entHeader(input logic [ENTRY_W-1:0] e);
    return e[27];
  endfunction

  function automatic logic [BITS_W-1:0] sampleBits(input logic [1:0] code);
    case (code)
      2'b01:   return 5'd14;
      2'b10:   return 5'd12;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/pktseq_table.sv
module pktseq_table #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      wrEn,
  input  logic [IDX_W-1:0]                          wrAddr,
  input  logic [pktseq_pkg::ENTRY_W-1:0]            wrData,
  output logic [DEPTH-1:0][pktseq_pkg::ENTRY_W-1:0] entries
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entries[i] <= '0;
      end else if (wrEn && (wrAddr == IDX_W'(i))) begin
        entries[i] <= wrData;
      end
    end
  end

endmodule

// File: rtl/pktseq_ctrl.sv
module pktseq_ctrl
  import pktseq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic               pktSentAck,
  input  logic               sampleValid,
  input  logic [ENTRY_W-1:0] curEntry,
  output logic               sampleReady,
  output logic [IDX_W-1:0]   curIdx,
  output seq_strobe_t        strobe
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_LSTART, ST_HDR, ST_DATA,
    ST_LEND, ST_WAIT, ST_ADV, ST_FIN
  } state_e;

  state_e            state, nextState;
  logic [SIZE_W-1:0] remain;

  // stage order inside one slot
  function automatic int stageRank(input state_e s);
    case (s)
      ST_LSTART: return 1;
      ST_HDR:    return 2;
      ST_DATA:   return 3;
      ST_LEND:   return 4;
      ST_WAIT:   return 5;
      default:   return 0;
    endcase
  endfunction

  function automatic state_e stageAfter(input state_e s, input logic [ENTRY_W-1:0] e);
    int r;
    r = stageRank(s);
    if (r < 1 && entLineStart(e))      return ST_LSTART;
    if (r < 2 && entHeader(e))         return ST_HDR;
    if (r < 3 && entSize(e) != '0)     return ST_DATA;
    if (r < 4 && entLineEnd(e))        return ST_LEND;
    if (r < 5 && entWaitAck(e))        return ST_WAIT;
    return ST_ADV;
  endfunction

  always_comb begin
    nextState   = state;
    strobe      = '0;
    strobe.kind = EV_NONE;
    sampleReady = 1'b0;
    case (state)
      ST_IDLE:  if (startPulse) nextState = ST_CHECK;
      ST_CHECK: nextState = entValid(curEntry) ? stageAfter(ST_CHECK, curEntry) : ST_ADV;
      ST_LSTART: begin
        strobe.emit = 1'b1;
        strobe.kind = EV_LSTART;
        nextState   = stageAfter(ST_LSTART, curEntry);
      end
      ST_HDR: begin
        strobe.emit = 1'b1;
        strobe.kind = EV_HDR;
        nextState   = stageAfter(ST_HDR, curEntry);
      end
      ST_DATA: begin
        sampleReady = 1'b1;
        if (sampleValid) begin
          strobe.take = 1'b1;
          if (remain == SIZE_W'(1)) nextState = stageAfter(ST_DATA, curEntry);
        end
      end
      ST_LEND: begin
        strobe.emit = 1'b1;
        strobe.kind = EV_LEND;
        nextState   = stageAfter(ST_LEND, curEntry);
      end
      ST_WAIT:  if (pktSentAck) nextState = ST_ADV;
      ST_ADV:   nextState = (curIdx == LAST_IDX) ? ST_FIN : ST_CHECK;
      ST_FIN: begin
        strobe.done = 1'b1;
        nextState   = ST_IDLE;
      end
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      curIdx <= '0;
      remain <= '0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE) begin
        curIdx <= '0;
      end else if (state == ST_ADV && curIdx != LAST_IDX) begin
        curIdx <= curIdx + 1'b1;
      end
      if (state != ST_DATA) begin
        remain <= entSize(curEntry);
      end else if (strobe.take) begin
        remain <= remain - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pktseq_dp.sv
module pktseq_dp
  import pktseq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  seq_strobe_t                    strobe,
  input  logic [IDX_W-1:0]               curIdx,
  input  logic [DEPTH-1:0][ENTRY_W-1:0]  entries,
  input  logic [15:0]                    sampleData,
  output logic                           evtValid,
  output logic [2:0]                     evtType,
  output logic [31:0]                    evtData,
  output logic                           doneOut
);

  localparam int SUM_W = SIZE_W + BITS_W + IDX_W + 1;

  logic [ENTRY_W-1:0] curEntry;
  logic [SUM_W-1:0]   bitSum;
  logic [SUM_W-1:0]   byteCount;
  logic               inChain;
  logic [15:0]        narrowed;
  logic [31:0]        nextData;

  assign curEntry = entries[curIdx];

  // packed bit total of the long packet that starts at curIdx
  always_comb begin
    bitSum  = '0;
    inChain = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (IDX_W'(j) == curIdx) begin
        inChain = 1'b1;
        bitSum  = bitSum + SUM_W'(entSize(entries[j])) * SUM_W'(sampleBits(entWidth(entries[j])));
      end else if (inChain && entValid(entries[j])) begin
        if (entHeader(entries[j])) begin
          inChain = 1'b0;
        end else begin
          bitSum = bitSum + SUM_W'(entSize(entries[j])) * SUM_W'(sampleBits(entWidth(entries[j])));
        end
      end
    end
    byteCount = (bitSum + SUM_W'(7)) >> 3;
  end

  always_comb begin
    case (entWidth(curEntry))
      2'b01:   narrowed = {2'b00, sampleData[15:2]};
      2'b10:   narrowed = {4'b0000, sampleData[15:4]};
      default: narrowed = sampleData;
    endcase
  end

  always_comb begin
    nextData = '0;
    if (strobe.take) begin
      nextData = {16'h0000, narrowed};
    end else if (strobe.emit && strobe.kind == EV_HDR) begin
      nextData = {entVc(curEntry), 30'(byteCount)};
    end else if (strobe.emit) begin
      nextData = {entVc(curEntry), 30'h0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtValid <= 1'b0;
      evtType  <= EV_NONE;
      evtData  <= '0;
      doneOut  <= 1'b0;
    end else begin
      evtValid <= strobe.emit | strobe.take;
      evtType  <= strobe.take ? EV_SAMPLE : (strobe.emit ? strobe.kind : EV_NONE);
      evtData  <= nextData;
      doneOut  <= strobe.done;
    end
  end

endmodule

// File: rtl/pktseq_top.sv
module pktseq_top
  import pktseq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [IDX_W-1:0] cfgWrAddr,
  input  logic [31:0]      cfgWrData,
  input  logic             startPulse,
  input  logic             pktSentAck,
  input  logic             sampleValid,
  input  logic [15:0]      sampleData,
  output logic             sampleReady,
  output logic             evtValid,
  output logic [2:0]       evtType,
  output logic [31:0]      evtData,
  output logic             doneOut
);

  logic [DEPTH-1:0][ENTRY_W-1:0] entries;
  logic [IDX_W-1:0]              curIdx;
  seq_strobe_t                   strobe;

  pktseq_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (cfgWrEn),
    .wrAddr  (cfgWrAddr),
    .wrData  (cfgWrData),
    .entries (entries)
  );

  pktseq_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .pktSentAck  (pktSentAck),
    .sampleValid (sampleValid),
    .curEntry    (entries[curIdx]),
    .sampleReady (sampleReady),
    .curIdx      (curIdx),
    .strobe      (strobe)
  );

  pktseq_dp #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .curIdx     (curIdx),
    .entries    (entries),
    .sampleData (sampleData),
    .evtValid   (evtValid),
    .evtType    (evtType),
    .evtData    (evtData),
    .doneOut    (doneOut)
  );

endmodule

// File: rtl/pktseq_checker.sv
module pktseq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sampleValid,
  input logic       sampleReady,
  input logic       evtValid,
  input logic [2:0] evtType,
  input logic       doneOut
);

  // R10: a handshake yields a sample event one cycle later
  a_r10_sample_after_handshake: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleReady) |=> (evtValid && evtType == 3'd3));

  // R10: no sample event without a handshake
  a_r10_no_sample_without_handshake: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleValid && sampleReady) |=> !(evtValid && evtType == 3'd3));

  // R9: done lasts a single cycle
  a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R9: done never shares a cycle with an event
  a_r9_done_apart_from_events: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !evtValid);

  // R6: no sample is accepted once the walk has finished
  a_r6_ready_low_at_done: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !sampleReady);

endmodule

bind pktseq_top pktseq_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .sampleReady (sampleReady),
  .evtValid    (evtValid),
  .evtType     (evtType),
  .doneOut     (doneOut)
);

// File: tb/pktseq_top_bench.sv
module pktseq_top_bench;

  localparam int DEPTH = 8;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rstN;
  logic             cfgWrEn;
  logic [IDX_W-1:0] cfgWrAddr;
  logic [31:0]      cfgWrData;
  logic             startPulse;
  logic             pktSentAck;
  logic             sampleValid = 1'b0;
  logic [15:0]      sampleData = '0;
  logic             sampleReady;
  logic             evtValid;
  logic [2:0]       evtType;
  logic [31:0]      evtData;
  logic             doneOut;

  always #4 clk = ~clk;

  pktseq_top #(.DEPTH(DEPTH)) u_pktseq_top (.*);

  logic [2:0]  capType[$];
  logic [31:0] capData[$];
  logic [2:0]  expType[$];
  logic [31:0] expData[$];
  logic [15:0] sampleQ[$];
  bit          sampleHold = 1'b0;
  int          doneCount;
  int          hsCount;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  // monitor and sample driver, away from the active edge
  always @(negedge clk) begin
    if (evtValid) begin
      capType.push_back(evtType);
      capData.push_back(evtData);
    end
    if (doneOut) doneCount++;
    sampleValid = !sampleHold && (sampleQ.size() > 0);
    sampleData  = (sampleQ.size() > 0) ? sampleQ[0] : 16'h0;
  end

  always @(posedge clk) begin
    if (rstN && sampleValid && sampleReady) begin
      void'(sampleQ.pop_front());
      hsCount++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkEntry(input bit valid, input bit lend, input bit lstart,
      input logic [1:0] vc, input logic [1:0] w, input logic [13:0] size, input bit waitAck, input bit hdr);
    logic [31:0] e;
    e = '0;
    e[0] = valid; e[1] = lend; e[2] = lstart; e[4:3] = vc; e[6:5] = w;
    e[22:9] = size; e[26] = waitAck; e[27] = hdr;
    return e;
  endfunction

  function automatic logic [31:0] narrowExp(input logic [15:0] d, input logic [1:0] w);
    if (w == 2'b01) return {18'h0, d[15:2]};
    if (w == 2'b10) return {20'h0, d[15:4]};
    return {16'h0, d};
  endfunction

  task automatic expect_evt(input logic [2:0] t, input logic [31:0] d);
    expType.push_back(t);
    expData.push_back(d);
  endtask

  task automatic wrEntry(input int idx, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = IDX_W'(idx); cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic clearTable();
    for (int i = 0; i < DEPTH; i++) wrEntry(i, 32'h0);
  endtask

  task automatic startRun();
    capType.delete(); capData.delete();
    doneCount = 0; hsCount = 0;
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
  endtask

  task automatic waitDone();
    while (doneCount == 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic compareEvents(input string req);
    chk(req, "event count", capType.size(), expType.size());
    for (int i = 0; i < expType.size() && i < capType.size(); i++) begin
      chk(req, $sformatf("event %0d type", i), 32'(capType[i]), 32'(expType[i]));
      chk(req, $sformatf("event %0d data", i), capData[i], expData[i]);
    end
    expType.delete(); expData.delete();
  endtask

  task automatic t_reset();
    chk("R1", "evtValid after reset", 32'(evtValid), 0);
    chk("R1", "sampleReady after reset", 32'(sampleReady), 0);
    chk("R1", "doneOut after reset", 32'(doneOut), 0);
    startRun();
    waitDone();
    chk("R1", "events from empty table", capType.size(), 0);
    chk("R9", "done pulses on empty table", doneCount, 1);
  endtask

  task automatic t_basic();
    clearTable();
    wrEntry(0, mkEntry(1, 1, 1, 2'd2, 2'b00, 14'd3, 0, 1));
    sampleQ.push_back(16'hA000); sampleQ.push_back(16'h1234); sampleQ.push_back(16'hFFFF);
    expect_evt(3'd1, {2'd2, 30'd0});
    expect_evt(3'd2, {2'd2, 30'd6});
    expect_evt(3'd3, 32'h0000A000);
    expect_evt(3'd3, 32'h00001234);
    expect_evt(3'd3, 32'h0000FFFF);
    expect_evt(3'd4, {2'd2, 30'd0});
    startRun();
    waitDone();
    chk("R6", "sampleReady after walk", 32'(sampleReady), 0);
    chk("R10", "sample events vs handshakes", 3, hsCount);
    chk("R9", "done pulse count", doneCount, 1);
    compareEvents("R3/R4/R6");
  endtask

  task automatic t_chain();
    clearTable();
    wrEntry(0, mkEntry(1, 0, 0, 2'd1, 2'b01, 14'd4, 0, 1));
    wrEntry(1, mkEntry(0, 1, 1, 2'd3, 2'b00, 14'd5, 0, 1));
    wrEntry(2, mkEntry(1, 1, 0, 2'd1, 2'b10, 14'd2, 0, 0));
    wrEntry(3, mkEntry(1, 0, 0, 2'd0, 2'b01, 14'd1, 0, 1));
    wrEntry(5, mkEntry(1, 0, 1, 2'd3, 2'b11, 14'd0, 0, 1));
    wrEntry(6, mkEntry(1, 0, 0, 2'd3, 2'b11, 14'd1, 0, 0));
    sampleQ.push_back(16'hFFFF); sampleQ.push_back(16'h8003);
    sampleQ.push_back(16'h1237); sampleQ.push_back(16'h0004);
    sampleQ.push_back(16'hABCD); sampleQ.push_back(16'h0010);
    sampleQ.push_back(16'hC001); sampleQ.push_back(16'h5A5A);
    expect_evt(3'd2, {2'd1, 30'((4 * 14 + 2 * 12 + 7) / 8)});
    expect_evt(3'd3, narrowExp(16'hFFFF, 2'b01));
    expect_evt(3'd3, narrowExp(16'h8003, 2'b01));
    expect_evt(3'd3, narrowExp(16'h1237, 2'b01));
    expect_evt(3'd3, narrowExp(16'h0004, 2'b01));
    expect_evt(3'd3, narrowExp(16'hABCD, 2'b10));
    expect_evt(3'd3, narrowExp(16'h0010, 2'b10));
    expect_evt(3'd4, {2'd1, 30'd0});
    expect_evt(3'd2, {2'd0, 30'((14 + 7) / 8)});
    expect_evt(3'd3, narrowExp(16'hC001, 2'b01));
    expect_evt(3'd1, {2'd3, 30'd0});
    expect_evt(3'd2, {2'd3, 30'((0 + 16 + 7) / 8)});
    expect_evt(3'd3, narrowExp(16'h5A5A, 2'b11));
    startRun();
    waitDone();
    chk("R2", "samples left unconsumed", sampleQ.size(), 0);
    compareEvents("R2/R5/R7");
  endtask

  task automatic t_wait();
    clearTable();
    wrEntry(0, mkEntry(1, 0, 0, 2'd0, 2'b00, 14'd1, 1, 1));
    sampleQ.push_back(16'h0042);
    expect_evt(3'd2, {2'd0, 30'd2});
    expect_evt(3'd3, 32'h00000042);
    startRun();
    while (capType.size() < 2) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R8", "done while holding", doneCount, 0);
    chk("R8", "events while holding", capType.size(), 2);
    pktSentAck = 1'b1;
    @(negedge clk);
    pktSentAck = 1'b0;
    waitDone();
    chk("R8", "done after acknowledge", doneCount, 1);
    compareEvents("R8");
  endtask

  task automatic t_start_ignored();
    clearTable();
    wrEntry(0, mkEntry(1, 0, 0, 2'd0, 2'b00, 14'd2, 0, 1));
    sampleHold = 1'b1;
    sampleQ.push_back(16'h1111); sampleQ.push_back(16'h2222);
    expect_evt(3'd2, {2'd0, 30'd4});
    expect_evt(3'd3, 32'h00001111);
    expect_evt(3'd3, 32'h00002222);
    startRun();
    repeat (5) @(negedge clk);
    chk("R6", "sampleReady with samples outstanding", 32'(sampleReady), 1);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    repeat (3) @(negedge clk);
    sampleHold = 1'b0;
    waitDone();
    repeat (40) @(negedge clk);
    chk("R11", "done pulses after second start", doneCount, 1);
    compareEvents("R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgWrAddr = '0; cfgWrData = '0;
    startPulse = 1'b0; pktSentAck = 1'b0;
    doneCount = 0; hsCount = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_chain();
    t_wait();
    t_start_ignored();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule